// File: doc/BRIEF.md
# System Control and NMI Status Ports

This block holds two byte-wide system-control ports. Port A carries a software-triggered alternate processor reset and a sticky watchdog status flag. Writing a 1 into the reset-request bit while that bit holds 0 starts a timed sequence. After a fixed settling delay, the `alt_rst` output goes high for a bounded number of clock cycles. Writing a 0 returns the bit to 0 and arms it for the next request.

Port B reports two error latches, one for memory parity and one for channel check. Either latch raises the nonmaskable interrupt output unless the external mask input is high. Software clears each latch with a port B write.

Both ports are read through combinational read-data buses. Writes are single-cycle strobes sampled on the rising clock edge. All timing is counted in clock cycles. With a 10 ns clock, the default pulse of 11 cycles lasts 110 ns, which falls inside a 100 to 125 ns window.

Top module: `sysctl_ports`

## Requirements
- R1: After reset, `alt_rst` and `nmi` are 0 and every bit of `rd_a` and `rd_b` reads 0. Bits of `rd_a` other than 0 and 4, and bits of `rd_b` other than 6 and 7, always read 0.
- R2: Suppose a port A write (`wr_a`) has `wdata[0]`=1 while the stored reset-request bit is 0 and no sequence is running. Then `alt_rst` stays low for DELAY_CYCLES clock cycles after that edge, and is then high for exactly PULSE_CYCLES cycles.
- R3: `rd_a[0]` returns the stored reset-request bit. A port A write with `wdata[0]`=0 clears it on the next edge. A write with `wdata[0]`=1 sets it.
- R4: A port A write of 1 while the stored bit is already 1 starts no pulse. A 0-to-1 write made while a sequence is running starts no second pulse, but the bit is still stored.
- R5: A cycle with `wdog_tmo` high sets `rd_a[4]` from the next edge. The flag stays set until reset, and port A writes do not change it.
- R6: A cycle with `parity_err` high sets `rd_b[7]`, and a cycle with `chan_chk` high sets `rd_b[6]`. Each takes effect from the next edge and holds after its input falls.
- R7: A port B write (`wr_b`) with `wdata[2]`=1 clears the parity latch, and one with `wdata[3]`=1 clears the channel latch. If the error input is high in the same cycle as the clear, the latch stays set.
- R8: `nmi` equals (parity latch OR channel latch) AND NOT `nmi_mask`, combinationally from the latches and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_a | input | 1 | Write strobe for port A |
| wr_b | input | 1 | Write strobe for port B |
| wdata | input | 8 | Write data for both ports |
| rd_a | output | 8 | Port A read data: bit 0 reset request, bit 4 watchdog flag |
| rd_b | output | 8 | Port B read data: bit 7 parity latch, bit 6 channel latch |
| parity_err | input | 1 | Parity error event |
| chan_chk | input | 1 | Channel check event |
| wdog_tmo | input | 1 | Watchdog time-out event |
| nmi_mask | input | 1 | High blocks the NMI output |
| nmi | output | 1 | Nonmaskable interrupt request |
| alt_rst | output | 1 | Alternate processor reset pulse |

## Verification
The bench builds the block with its defaults, DELAY_CYCLES=4 and PULSE_CYCLES=11. With these values the whole reset sequence takes 15 cycles. That is short enough for the bench to count the delay and the width cycle by cycle. It also leaves room to place a 0-then-1 rewrite inside a running sequence and confirm that no second pulse follows.

// File: rtl/sysctl_ports.sv
module sysctl_ports #(
  parameter int DELAY_CYCLES = 4,
  parameter int PULSE_CYCLES = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [7:0] wdata,
  output logic [7:0] rd_a,
  output logic [7:0] rd_b,
  input  logic       parity_err,
  input  logic       chan_chk,
  input  logic       wdog_tmo,
  input  logic       nmi_mask,
  output logic       nmi,
  output logic       alt_rst
);
  localparam int SEQ_LEN = DELAY_CYCLES + PULSE_CYCLES;
  localparam int CW = $clog2(SEQ_LEN + 1);

  logic          req_bit, wdog_q, par_q, chk_q;
  logic [CW-1:0] seq_cnt;

  wire seq_idle = (seq_cnt == '0);
  wire start    = wr_a && wdata[0] && !req_bit && seq_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_bit <= 1'b0;
      seq_cnt <= '0;
    end else begin
      if (wr_a) req_bit <= wdata[0];
      if (start) seq_cnt <= CW'(SEQ_LEN);
      else if (!seq_idle) seq_cnt <= seq_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdog_q <= 1'b0;
    else if (wdog_tmo) wdog_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      chk_q <= 1'b0;
    end else begin
      if (parity_err) par_q <= 1'b1;
      else if (wr_b && wdata[2]) par_q <= 1'b0;
      if (chan_chk) chk_q <= 1'b1;
      else if (wr_b && wdata[3]) chk_q <= 1'b0;
    end
  end

  assign alt_rst = !seq_idle && (seq_cnt <= CW'(PULSE_CYCLES));
  assign nmi     = (par_q | chk_q) & ~nmi_mask;
  assign rd_a    = {3'b000, wdog_q, 3'b000, req_bit};
  assign rd_b    = {par_q, chk_q, 6'b000000};
endmodule

module sysctl_ports_chk #(
  parameter int PULSE_CYCLES = 11
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_a,
  input logic       wr_b,
  input logic [7:0] wdata,
  input logic [7:0] rd_a,
  input logic [7:0] rd_b,
  input logic       parity_err,
  input logic       nmi_mask,
  input logic       nmi,
  input logic       alt_rst
);
  logic [15:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else if (alt_rst) hi_len <= hi_len + 1'b1;
    else hi_len <= '0;
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_rst && hi_len != 0) |-> hi_len == 16'(PULSE_CYCLES));
  // R8
  nmi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_mask |-> !nmi);
  // R8
  nmi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_mask && (rd_b[7] || rd_b[6])) |-> nmi);
  // R5
  wdog_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a[4] |=> rd_a[4]);
  // R3
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !wdata[0]) |=> !rd_a[0]);
  // R6
  parity_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> rd_b[7]);
  // R7
  parity_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && wdata[2] && !parity_err) |=> !rd_b[7]);
endmodule

bind sysctl_ports sysctl_ports_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .wdata(wdata),
  .rd_a(rd_a), .rd_b(rd_b), .parity_err(parity_err), .nmi_mask(nmi_mask),
  .nmi(nmi), .alt_rst(alt_rst)
);

// File: tb/tb_sysctl_ports.sv
module tb_sysctl_ports;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;
  localparam int PW  = 11;

  logic clk = 0, rst_n = 0, wr_a = 0, wr_b = 0;
  logic [7:0] wdata = 0;
  logic parity_err = 0, chan_chk = 0, wdog_tmo = 0, nmi_mask = 0;
  logic [7:0] rd_a, rd_b;
  logic nmi, alt_rst;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_ports #(.DELAY_CYCLES(DLY), .PULSE_CYCLES(PW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .wdata(wdata),
    .rd_a(rd_a), .rd_b(rd_b), .parity_err(parity_err), .chan_chk(chan_chk),
    .wdog_tmo(wdog_tmo), .nmi_mask(nmi_mask), .nmi(nmi), .alt_rst(alt_rst));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_a(input logic [7:0] d);
    wr_a = 1; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_a = 0; wdata = 0;
  endtask

  task automatic write_b(input logic [7:0] d);
    wr_b = 1; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_b = 0; wdata = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // count low cycles before the pulse and its width; returns -1 if none
  task automatic measure(output int lo, output int hi);
    lo = 0; hi = 0;
    while (!alt_rst && lo < 40) begin @(negedge clk); lo++; end
    if (!alt_rst) begin lo = -1; return; end
    while (alt_rst && hi < 40) begin @(negedge clk); hi++; end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd_a", rd_a, 0);
    chk("R1 rd_b", rd_b, 0);
    chk("R1 alt_rst", alt_rst, 0);
    chk("R1 nmi", nmi, 0);
  endtask

  task automatic t_pulse();
    int lo, hi;
    write_a(8'hFF);
    chk("R1 rd_a unused bits", rd_a, 1);
    measure(lo, hi);
    chk("R2 delay", lo, DLY);
    chk("R2 width", hi, PW);
  endtask

  task automatic t_rewrite_one();
    int lo, hi;
    write_a(8'h01);
    measure(lo, hi);
    chk("R4 no pulse on 1 over 1", lo, -1);
    write_a(8'h00);
    chk("R3 cleared", rd_a[0], 0);
    write_a(8'h01);
    chk("R3 set", rd_a[0], 1);
    measure(lo, hi);
    chk("R2 retrigger delay", lo, DLY);
    chk("R2 retrigger width", hi, PW);
    write_a(8'h00);
  endtask

  task automatic t_busy();
    int lo, hi;
    write_a(8'h01);
    write_a(8'h00);
    write_a(8'h01);
    chk("R4 bit stored while busy", rd_a[0], 1);
    measure(lo, hi);
    chk("R4 busy first width", hi, PW);
    measure(lo, hi);
    chk("R4 no second pulse", lo, -1);
    write_a(8'h00);
  endtask

  task automatic t_errors();
    parity_err = 1; @(negedge clk); parity_err = 0;
    chk("R6 parity latched", rd_b, 8'h80);
    chk("R8 nmi from parity", nmi, 1);
    nmi_mask = 1; #1;
    chk("R8 nmi masked", nmi, 0);
    nmi_mask = 0; #1;
    chan_chk = 1; @(negedge clk); chan_chk = 0;
    repeat (3) @(negedge clk);
    chk("R6 both latched held", rd_b, 8'hC0);
    write_b(8'h04);
    chk("R7 parity cleared", rd_b, 8'h40);
    chk("R8 nmi from channel", nmi, 1);
    chan_chk = 1; write_b(8'h08); chan_chk = 0;
    chk("R7 set wins over clear", rd_b[6], 1);
    write_b(8'h08);
    chk("R7 channel cleared", rd_b, 0);
    chk("R8 nmi off", nmi, 0);
  endtask

  task automatic t_wdog();
    wdog_tmo = 1; @(negedge clk); wdog_tmo = 0;
    chk("R5 wdog set", rd_a[4], 1);
    write_a(8'h00);
    repeat (3) @(negedge clk);
    chk("R5 wdog sticky", rd_a, 8'h10);
    do_reset();
    chk("R5 wdog cleared by reset", rd_a[4], 0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_pulse();
        t_rewrite_one();
        t_busy();
        t_errors();
        t_wdog();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule